// File: doc/BRIEF.md
# Instruction Decoder and Immediate Generator

This block turns one 32-bit fixed-length RISC instruction word, together with the address the word was fetched from, into everything a simple integer pipeline needs before execution. It covers twenty instructions:

- three-register arithmetic and compare;
- register jump;
- immediate arithmetic, compare, OR and load-upper;
- signed and unsigned loads of byte, half-word and word width;
- stores of byte, half-word and word width;
- equal and not-equal branches;
- direct jump and jump-and-link.

The word carries one of three layouts. In the register layout the fields are, from bit 31 down: a 6-bit opcode, three 5-bit register numbers (first source, second source, destination), a 5-bit shift amount and a 6-bit function code. In the immediate layout the two source register numbers are followed by a 16-bit constant. In the jump layout the 6-bit opcode is followed by a 26-bit target field.

The decoder is purely combinational. For every word it gives the register read addresses and the resolved destination register. It also gives the ALU operation and the operand source, the memory direction, access size and signedness, and the branch and jump kinds. Finally it computes the 32-bit immediate, the branch target, the jump target and the return address. A word whose opcode or function code is not in the subset raises an illegal flag and produces no side effects.

Top module: `insn_decoder`

## Requirements
- R1: `rs_addr_o` is bits 25:21 of the word, `rt_addr_o` is bits 20:16, `shamt_o` is bits 10:6, and `pc_plus4_o` is the PC plus 4, for every word.
- R2: Opcode 0 with function 32, 34 or 42 selects ALU code 0 (add), 1 (subtract) or 2 (signed set-less-than) respectively. For these the destination is bits 15:11 and the operand comes from a register (`alu_src_imm_o`=0).
- R3: Opcode 0 with function 8 sets jump code 2 (through register rs), with no register write and no memory access.
- R4: Opcode 8 (ALU code 0) and opcode 10 (ALU code 2) use the immediate operand. The immediate is bits 15:0 sign-extended to 32 bits, and the destination is bits 20:16.
- R5: Opcode 13 selects ALU code 3 (OR) with bits 15:0 zero-extended. Opcode 15 selects ALU code 4 (pass operand B) with the immediate equal to bits 15:0 placed in bits 31:16 and zeros below. Both write to bits 20:16.
- R6: Loads raise `mem_rd_o`, use ALU code 0 with the sign-extended offset, and write to bits 20:16. The five loads are:
  - opcode 35: word (size code 2);
  - opcode 33: signed half (size 1);
  - opcode 37: unsigned half (size 1);
  - opcode 32: signed byte (size 0);
  - opcode 36: unsigned byte (size 0).
  `mem_unsigned_o` is 1 only for opcodes 37 and 36.
- R7: Opcodes 43, 41 and 40 are stores of size 2, 1 and 0 respectively. Each raises `mem_wr_o`, uses ALU code 0 with the sign-extended offset, and writes no register.
- R8: Opcode 4 gives branch code 1 (equal) and opcode 5 gives branch code 2 (not equal). Both use ALU code 1 and write no register. `branch_tgt_o` is always PC+4 plus the sign-extended immediate shifted left by 2.
- R9: Opcodes 2 and 3 give jump code 1. `jump_tgt_o` is always bits 31:28 of PC+4 joined with bits 25:0 of the word and two zero bits. Opcode 3 also sets `link_o` and writes register 31.
- R10: `reg_we_o` is 1 exactly when the instruction has a destination and that destination is not register 0. `dest_addr_o` is 0 whenever the instruction writes no register.
- R11: Any other opcode, or opcode 0 with any other function code, raises `illegal_o` with no register write, no memory access, branch code 0, jump code 0 and ALU code 0.
- R12: `mem_rd_o` and `mem_wr_o` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_i | input | 32 | Instruction word |
| pc_i | input | 32 | Address of the instruction |
| rs_addr_o | output | 5 | First source register number |
| rt_addr_o | output | 5 | Second source register number |
| shamt_o | output | 5 | Shift amount field |
| dest_addr_o | output | 5 | Resolved destination register |
| reg_we_o | output | 1 | Register write enable |
| alu_op_o | output | 3 | ALU operation code |
| alu_src_imm_o | output | 1 | ALU operand B is the immediate |
| mem_rd_o | output | 1 | Memory read |
| mem_wr_o | output | 1 | Memory write |
| mem_size_o | output | 2 | Access size: 0 byte, 1 half, 2 word |
| mem_unsigned_o | output | 1 | Load result is zero-extended |
| branch_o | output | 2 | Branch kind: 0 none, 1 equal, 2 not equal |
| jump_o | output | 2 | Jump kind: 0 none, 1 direct, 2 register |
| link_o | output | 1 | Write data is the return address |
| illegal_o | output | 1 | Unsupported instruction |
| imm_o | output | 32 | Generated immediate |
| branch_tgt_o | output | 32 | Branch target address |
| jump_tgt_o | output | 32 | Direct jump target address |
| pc_plus4_o | output | 32 | Return address, PC plus 4 |

## Verification
Two functions can fall on the same word. The first is destination selection with its write-enable suppression. The second is immediate formatting together with target arithmetic.

An immediate instruction that names register 0 as its destination must still produce a correctly formatted immediate while its write is dropped. A jump-and-link must write register 31 in the same evaluation that forms its direct target from the upper PC bits.

Directed words provoke these cases: addi, lui and a load with rt=0, jal with a PC near the top of memory, and branches with negative offsets. Random words drawn from the supported and unsupported encodings cover the rest. Every output of each word is judged at once against a bench model of the requirements, so a fault in either function shows up on the same word.

// File: rtl/insn_dec_pkg.sv
package insn_dec_pkg;

    localparam int XLEN    = 32;
    localparam int RADDR_W = 5;
    localparam int OPC_W   = 6;
    localparam int FUNCT_W = 6;
    localparam int IMM_W   = 16;
    localparam int TGT_W   = XLEN - OPC_W;
    localparam int SEG_W   = XLEN - TGT_W - 2;
    localparam logic [RADDR_W-1:0] LINK_REG = '1;

    localparam logic [OPC_W-1:0] OPC_RTYPE = 6'd0;
    localparam logic [OPC_W-1:0] OPC_J     = 6'd2;
    localparam logic [OPC_W-1:0] OPC_JAL   = 6'd3;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'd4;
    localparam logic [OPC_W-1:0] OPC_BNE   = 6'd5;
    localparam logic [OPC_W-1:0] OPC_ADDI  = 6'd8;
    localparam logic [OPC_W-1:0] OPC_SLTI  = 6'd10;
    localparam logic [OPC_W-1:0] OPC_ORI   = 6'd13;
    localparam logic [OPC_W-1:0] OPC_LUI   = 6'd15;
    localparam logic [OPC_W-1:0] OPC_LB    = 6'd32;
    localparam logic [OPC_W-1:0] OPC_LH    = 6'd33;
    localparam logic [OPC_W-1:0] OPC_LW    = 6'd35;
    localparam logic [OPC_W-1:0] OPC_LBU   = 6'd36;
    localparam logic [OPC_W-1:0] OPC_LHU   = 6'd37;
    localparam logic [OPC_W-1:0] OPC_SB    = 6'd40;
    localparam logic [OPC_W-1:0] OPC_SH    = 6'd41;
    localparam logic [OPC_W-1:0] OPC_SW    = 6'd43;

    localparam logic [FUNCT_W-1:0] FN_JR  = 6'd8;
    localparam logic [FUNCT_W-1:0] FN_ADD = 6'd32;
    localparam logic [FUNCT_W-1:0] FN_SUB = 6'd34;
    localparam logic [FUNCT_W-1:0] FN_SLT = 6'd42;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0, ALU_SUB = 3'd1, ALU_SLT = 3'd2, ALU_OR = 3'd3, ALU_PASSB = 3'd4
    } alu_op_e;

    typedef enum logic [1:0] { SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2 } mem_size_e;
    typedef enum logic [1:0] { BR_NONE = 2'd0, BR_EQ = 2'd1, BR_NE = 2'd2 } branch_e;
    typedef enum logic [1:0] { JMP_NONE = 2'd0, JMP_DIRECT = 2'd1, JMP_REG = 2'd2 } jump_e;
    typedef enum logic [1:0] { IMM_SEXT = 2'd0, IMM_ZEXT = 2'd1, IMM_UPPER = 2'd2 } imm_kind_e;
    typedef enum logic [1:0] { DST_NONE = 2'd0, DST_RD = 2'd1, DST_RT = 2'd2, DST_LINK = 2'd3 } dst_sel_e;

    typedef struct packed {
        logic [OPC_W-1:0]   opcode;
        logic [RADDR_W-1:0] rs;
        logic [RADDR_W-1:0] rt;
        logic [RADDR_W-1:0] rd;
        logic [RADDR_W-1:0] shamt;
        logic [FUNCT_W-1:0] funct;
        logic [IMM_W-1:0]   imm16;
        logic [TGT_W-1:0]   tgt26;
    } fields_t;

    typedef struct packed {
        alu_op_e   alu_op;
        logic      alu_src_imm;
        logic      mem_rd;
        logic      mem_wr;
        mem_size_e mem_size;
        logic      mem_unsigned;
        branch_e   branch;
        jump_e     jump;
        dst_sel_e  dst_sel;
        imm_kind_e imm_kind;
        logic      illegal;
    } ctrl_t;

    function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] v);
        return {{(XLEN-IMM_W){v[IMM_W-1]}}, v};
    endfunction

endpackage

// File: rtl/insn_fields.sv
module insn_fields
    import insn_dec_pkg::*;
(
    input  logic [XLEN-1:0] insn_i,
    output fields_t         fields_o
);
    localparam int RS_LSB = XLEN - OPC_W - RADDR_W;
    localparam int RT_LSB = RS_LSB - RADDR_W;
    localparam int RD_LSB = RT_LSB - RADDR_W;
    localparam int SH_LSB = RD_LSB - RADDR_W;

    always_comb begin
        fields_o.opcode = insn_i[XLEN-1 -: OPC_W];
        fields_o.rs     = insn_i[RS_LSB +: RADDR_W];
        fields_o.rt     = insn_i[RT_LSB +: RADDR_W];
        fields_o.rd     = insn_i[RD_LSB +: RADDR_W];
        fields_o.shamt  = insn_i[SH_LSB +: RADDR_W];
        fields_o.funct  = insn_i[FUNCT_W-1:0];
        fields_o.imm16  = insn_i[IMM_W-1:0];
        fields_o.tgt26  = insn_i[TGT_W-1:0];
    end
endmodule

// File: rtl/insn_ctrl.sv
module insn_ctrl
    import insn_dec_pkg::*;
(
    input  logic [OPC_W-1:0]   opcode_i,
    input  logic [FUNCT_W-1:0] funct_i,
    output ctrl_t              ctrl_o
);
    always_comb begin
        ctrl_o              = '0;
        ctrl_o.alu_op       = ALU_ADD;
        ctrl_o.mem_size     = SZ_WORD;
        ctrl_o.branch       = BR_NONE;
        ctrl_o.jump         = JMP_NONE;
        ctrl_o.dst_sel      = DST_NONE;
        ctrl_o.imm_kind     = IMM_SEXT;
        unique case (opcode_i)
            OPC_RTYPE: begin
                unique case (funct_i)
                    FN_ADD: ctrl_o.dst_sel = DST_RD;
                    FN_SUB: begin ctrl_o.dst_sel = DST_RD; ctrl_o.alu_op = ALU_SUB; end
                    FN_SLT: begin ctrl_o.dst_sel = DST_RD; ctrl_o.alu_op = ALU_SLT; end
                    FN_JR:  ctrl_o.jump = JMP_REG;
                    default: ctrl_o.illegal = 1'b1;
                endcase
            end
            OPC_ADDI: begin ctrl_o.dst_sel = DST_RT; ctrl_o.alu_src_imm = 1'b1; end
            OPC_SLTI: begin
                ctrl_o.dst_sel = DST_RT; ctrl_o.alu_src_imm = 1'b1; ctrl_o.alu_op = ALU_SLT;
            end
            OPC_ORI: begin
                ctrl_o.dst_sel = DST_RT; ctrl_o.alu_src_imm = 1'b1;
                ctrl_o.alu_op = ALU_OR; ctrl_o.imm_kind = IMM_ZEXT;
            end
            OPC_LUI: begin
                ctrl_o.dst_sel = DST_RT; ctrl_o.alu_src_imm = 1'b1;
                ctrl_o.alu_op = ALU_PASSB; ctrl_o.imm_kind = IMM_UPPER;
            end
            OPC_LW, OPC_LH, OPC_LHU, OPC_LB, OPC_LBU: begin
                ctrl_o.dst_sel      = DST_RT;
                ctrl_o.alu_src_imm  = 1'b1;
                ctrl_o.mem_rd       = 1'b1;
                ctrl_o.mem_unsigned = (opcode_i == OPC_LHU) || (opcode_i == OPC_LBU);
                ctrl_o.mem_size     = (opcode_i == OPC_LW) ? SZ_WORD :
                                      ((opcode_i == OPC_LH) || (opcode_i == OPC_LHU)) ? SZ_HALF : SZ_BYTE;
            end
            OPC_SW, OPC_SH, OPC_SB: begin
                ctrl_o.alu_src_imm = 1'b1;
                ctrl_o.mem_wr      = 1'b1;
                ctrl_o.mem_size    = (opcode_i == OPC_SW) ? SZ_WORD :
                                     (opcode_i == OPC_SH) ? SZ_HALF : SZ_BYTE;
            end
            OPC_BEQ: begin ctrl_o.branch = BR_EQ; ctrl_o.alu_op = ALU_SUB; end
            OPC_BNE: begin ctrl_o.branch = BR_NE; ctrl_o.alu_op = ALU_SUB; end
            OPC_J:   ctrl_o.jump = JMP_DIRECT;
            OPC_JAL: begin ctrl_o.jump = JMP_DIRECT; ctrl_o.dst_sel = DST_LINK; end
            default: ctrl_o.illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/insn_imm_gen.sv
module insn_imm_gen
    import insn_dec_pkg::*;
(
    input  logic [IMM_W-1:0] imm16_i,
    input  logic [TGT_W-1:0] tgt26_i,
    input  imm_kind_e        kind_i,
    input  logic [XLEN-1:0]  pc_i,
    output logic [XLEN-1:0]  imm_o,
    output logic [XLEN-1:0]  branch_tgt_o,
    output logic [XLEN-1:0]  jump_tgt_o,
    output logic [XLEN-1:0]  pc_plus4_o
);
    logic [XLEN-1:0] sext;

    always_comb begin
        sext = sext_imm(imm16_i);
        unique case (kind_i)
            IMM_ZEXT:  imm_o = {{(XLEN-IMM_W){1'b0}}, imm16_i};
            IMM_UPPER: imm_o = {imm16_i, {(XLEN-IMM_W){1'b0}}};
            default:   imm_o = sext;
        endcase
        pc_plus4_o   = pc_i + XLEN'(4);
        branch_tgt_o = pc_plus4_o + {sext[XLEN-3:0], 2'b00};
        jump_tgt_o   = {pc_plus4_o[XLEN-1 -: SEG_W], tgt26_i, 2'b00};
    end
endmodule

// File: rtl/insn_decoder.sv
module insn_decoder
    import insn_dec_pkg::*;
(
    input  logic [31:0] insn_i,
    input  logic [31:0] pc_i,
    output logic [4:0]  rs_addr_o,
    output logic [4:0]  rt_addr_o,
    output logic [4:0]  shamt_o,
    output logic [4:0]  dest_addr_o,
    output logic        reg_we_o,
    output logic [2:0]  alu_op_o,
    output logic        alu_src_imm_o,
    output logic        mem_rd_o,
    output logic        mem_wr_o,
    output logic [1:0]  mem_size_o,
    output logic        mem_unsigned_o,
    output logic [1:0]  branch_o,
    output logic [1:0]  jump_o,
    output logic        link_o,
    output logic        illegal_o,
    output logic [31:0] imm_o,
    output logic [31:0] branch_tgt_o,
    output logic [31:0] jump_tgt_o,
    output logic [31:0] pc_plus4_o
);
    fields_t f;
    ctrl_t   c;

    insn_fields u_fields (.insn_i(insn_i), .fields_o(f));

    insn_ctrl u_ctrl (.opcode_i(f.opcode), .funct_i(f.funct), .ctrl_o(c));

    insn_imm_gen u_imm (
        .imm16_i      (f.imm16),
        .tgt26_i      (f.tgt26),
        .kind_i       (c.imm_kind),
        .pc_i         (pc_i),
        .imm_o        (imm_o),
        .branch_tgt_o (branch_tgt_o),
        .jump_tgt_o   (jump_tgt_o),
        .pc_plus4_o   (pc_plus4_o)
    );

    always_comb begin
        rs_addr_o      = f.rs;
        rt_addr_o      = f.rt;
        shamt_o        = f.shamt;
        alu_op_o       = c.alu_op;
        alu_src_imm_o  = c.alu_src_imm;
        mem_rd_o       = c.mem_rd;
        mem_wr_o       = c.mem_wr;
        mem_size_o     = c.mem_size;
        mem_unsigned_o = c.mem_unsigned;
        branch_o       = c.branch;
        jump_o         = c.jump;
        illegal_o      = c.illegal;
        link_o         = (c.dst_sel == DST_LINK);
        unique case (c.dst_sel)
            DST_RD:   dest_addr_o = f.rd;
            DST_RT:   dest_addr_o = f.rt;
            DST_LINK: dest_addr_o = LINK_REG;
            default:  dest_addr_o = '0;
        endcase
        reg_we_o = (dest_addr_o != '0);
    end

    always_comb begin
        AST_MEM_EXCLUSIVE: assert (!(mem_rd_o && mem_wr_o)); // R12
        AST_STORE_NO_WRITE: assert (!mem_wr_o || !reg_we_o); // R7
        AST_ILLEGAL_QUIET: assert (!illegal_o || (!reg_we_o && !mem_rd_o && !mem_wr_o
                                   && branch_o == 2'd0 && jump_o == 2'd0)); // R11
        AST_BRANCH_SUBTRACTS: assert (branch_o == 2'd0 || alu_op_o == 3'd1); // R8
        AST_LINK_TO_R31: assert (!link_o || (jump_o == 2'd1 && dest_addr_o == 5'd31)); // R9
        AST_UPPER_LOW_CLEAR: assert (alu_op_o != 3'd4 || imm_o[15:0] == 16'h0); // R5
    end
endmodule

// File: tb/insn_decoder_tb.sv
module insn_decoder_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [31:0] insn = 32'h0;
    logic [31:0] pc   = 32'h0;
    logic [4:0]  rs_addr, rt_addr, shamt, dest_addr;
    logic        reg_we, alu_src_imm, mem_rd, mem_wr, mem_unsigned, link, illegal;
    logic [2:0]  alu_op;
    logic [1:0]  mem_size, branch, jump;
    logic [31:0] imm, branch_tgt, jump_tgt, pc_plus4;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    insn_decoder dut_i (
        .insn_i(insn), .pc_i(pc),
        .rs_addr_o(rs_addr), .rt_addr_o(rt_addr), .shamt_o(shamt), .dest_addr_o(dest_addr),
        .reg_we_o(reg_we), .alu_op_o(alu_op), .alu_src_imm_o(alu_src_imm),
        .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .mem_size_o(mem_size), .mem_unsigned_o(mem_unsigned),
        .branch_o(branch), .jump_o(jump), .link_o(link), .illegal_o(illegal),
        .imm_o(imm), .branch_tgt_o(branch_tgt), .jump_tgt_o(jump_tgt), .pc_plus4_o(pc_plus4)
    );

    function automatic logic [255:0] model(input logic [31:0] w, input logic [31:0] p, output string tag);
        logic [5:0] op = w[31:26];
        logic [5:0] fn = w[5:0];
        logic [31:0] sx = {{16{w[15]}}, w[15:0]};
        logic [31:0] im = sx;
        logic [31:0] p4 = p + 32'd4;
        logic [4:0] dst = 5'd0;
        logic [2:0] alu = 3'd0;
        logic src = 0, mrd = 0, mwr = 0, uns = 0, lnk = 0, ill = 0;
        logic [1:0] sz = 2'd2, br = 2'd0, jp = 2'd0;
        tag = "R1";
        case (op)
            6'd0: case (fn)
                6'd32: begin dst = w[15:11]; tag = "R2"; end
                6'd34: begin dst = w[15:11]; alu = 3'd1; tag = "R2"; end
                6'd42: begin dst = w[15:11]; alu = 3'd2; tag = "R2"; end
                6'd8:  begin jp = 2'd2; tag = "R3"; end
                default: begin ill = 1; tag = "R11"; end
            endcase
            6'd8:  begin dst = w[20:16]; src = 1; tag = "R4"; end
            6'd10: begin dst = w[20:16]; src = 1; alu = 3'd2; tag = "R4"; end
            6'd13: begin dst = w[20:16]; src = 1; alu = 3'd3; im = {16'h0, w[15:0]}; tag = "R5"; end
            6'd15: begin dst = w[20:16]; src = 1; alu = 3'd4; im = {w[15:0], 16'h0}; tag = "R5"; end
            6'd35, 6'd33, 6'd37, 6'd32, 6'd36: begin
                dst = w[20:16]; src = 1; mrd = 1; tag = "R6";
                sz  = (op == 6'd35) ? 2'd2 : (op == 6'd33 || op == 6'd37) ? 2'd1 : 2'd0;
                uns = (op == 6'd37 || op == 6'd36);
            end
            6'd43, 6'd41, 6'd40: begin
                src = 1; mwr = 1; tag = "R7";
                sz  = (op == 6'd43) ? 2'd2 : (op == 6'd41) ? 2'd1 : 2'd0;
            end
            6'd4: begin br = 2'd1; alu = 3'd1; tag = "R8"; end
            6'd5: begin br = 2'd2; alu = 3'd1; tag = "R8"; end
            6'd2: begin jp = 2'd1; tag = "R9"; end
            6'd3: begin jp = 2'd1; dst = 5'd31; lnk = 1; tag = "R9"; end
            default: begin ill = 1; tag = "R11"; end
        endcase
        if (dst == 5'd0 && (op == 6'd0 || (op >= 6'd8 && op <= 6'd15) || (op >= 6'd32 && op <= 6'd37)) && !ill)
            tag = "R10";
        return 256'({w[25:21], w[20:16], w[10:6], dst, (dst != 5'd0), alu, src, mrd, mwr, sz, uns,
                     br, jp, lnk, ill, im, p4 + {sx[29:0], 2'b00}, {p4[31:28], w[25:0], 2'b00}, p4});
    endfunction

    function automatic logic [255:0] actual();
        return 256'({rs_addr, rt_addr, shamt, dest_addr, reg_we, alu_op, alu_src_imm, mem_rd, mem_wr,
                     mem_size, mem_unsigned, branch, jump, link, illegal, imm, branch_tgt, jump_tgt, pc_plus4});
    endfunction

    task automatic apply(input logic [31:0] w, input logic [31:0] p);
        logic [255:0] exp_v;
        string tag;
        @(negedge clk);
        insn = w;
        pc   = p;
        #5;
        exp_v = model(w, p, tag);
        n_checks++;
        if (actual() !== exp_v) begin
            n_fail++;
            $display("FAIL %s insn=%h pc=%h actual=%h expected=%h", tag, w, p, actual(), exp_v);
        end
        n_checks++;
        if (mem_rd && mem_wr) begin
            n_fail++;
            $display("FAIL R12 insn=%h actual rd=1 wr=1 expected not both", w);
        end
    endtask

    localparam logic [5:0] OPS [20] = '{6'd0, 6'd0, 6'd0, 6'd0, 6'd8, 6'd10, 6'd13, 6'd15,
        6'd35, 6'd33, 6'd37, 6'd32, 6'd36, 6'd43, 6'd41, 6'd40, 6'd4, 6'd5, 6'd2, 6'd3};
    localparam logic [5:0] FNS [4] = '{6'd32, 6'd34, 6'd42, 6'd8};

    initial begin
        void'($urandom(32'd2024));
        repeat (2) @(posedge clk);
        rst = 1'b0;
        apply(32'h0000_0000, 32'h0);          // R11 all-zero word after reset
        apply(32'h0232_4020, 32'h0040_0000);  // R2 add rd=8, R1 fields
        apply(32'h0232_4022, 32'h0040_0004);  // R2 sub
        apply(32'h0232_402A, 32'h0040_0008);  // R2 slt
        apply(32'h0120_0008, 32'h0040_000C);  // R3 jr
        apply(32'h2128_FFF0, 32'h0);          // R4 addi negative
        apply(32'h2920_8000, 32'h0);          // R4 slti most negative
        apply(32'h3508_8001, 32'h0);          // R5 ori high bit zero-extended
        apply(32'h3C08_ABCD, 32'h0);          // R5 lui
        apply(32'h3C00_1234, 32'h0);          // R10 lui to register 0
        apply(32'h2000_0005, 32'h0);          // R10 addi to register 0
        apply(32'h8E48_0018, 32'h0);          // R6 lw
        apply(32'h8660_FFFE, 32'h0);          // R6 lh to register 0 (R10)
        apply(32'h9668_0002, 32'h0);          // R6 lhu
        apply(32'h8268_0001, 32'h0);          // R6 lb
        apply(32'h9268_0001, 32'h0);          // R6 lbu
        apply(32'hAE48_0018, 32'h0);          // R7 sw
        apply(32'hA668_0006, 32'h0);          // R7 sh
        apply(32'hA268_0006, 32'h0);          // R7 sb
        apply(32'h1274_FFFF, 32'h0000_1000);  // R8 beq backwards
        apply(32'h1674_7FFF, 32'h0000_1000);  // R8 bne far forward
        apply(32'h0BFF_FFFF, 32'hFFFF_FFFC);  // R9 j, PC+4 wraps
        apply(32'h0C00_0010, 32'hE000_0000);  // R9 jal
        apply(32'h0232_4021, 32'h0);          // R11 unknown funct
        apply(32'hFC00_0000, 32'h0);          // R11 unknown opcode
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] w = $urandom;
            logic [31:0] p = $urandom;
            int k = $urandom_range(0, 21);
            if (k < 20) begin
                w[31:26] = OPS[k];
                if (k < 4) w[5:0] = FNS[k];
            end
            apply(w, p);
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule